// File: doc/BRIEF.md
# Fractional-Increment Realtime Counter

This block keeps a 64-bit count that advances at a fixed rate even when the clock driving it changes frequency. On every input clock it adds a programmed fraction, numerator over denominator, to a phase accumulator. Each time that phase passes a whole unit, the count goes up by one and a single-cycle tick pulse marks the step. The mean count rate is therefore the input rate times numerator divided by denominator. For example, 8/25 of a 19.2 MHz clock, 4/25 of 38.4 MHz, 64/125 of 12 MHz, 192/625 of 20 MHz and 768/1625 of 13 MHz all give 6.144 MHz. Unusual pairs such as 75/244 work the same way.

Software sets the ratio through a small register port. It has a write strobe, a byte address and a 32-bit data word, plus an address-driven combinational read. Each ratio term sits in the low 12 bits of its own 32-bit word. The upper 20 bits are stored and read back, but the ratio arithmetic never uses them. Software can therefore read-modify-write the word without disturbing any other content. Software also reports the resulting frequency rounded up: input rate times numerator, divided by denominator.

Top module: `frac_rate_counter`

## Requirements
- R1: A synchronous active-low reset clears the count to zero, drops the tick, clears the phase accumulator, and clears both ratio registers, so that both read back as zero.
- R2: With a usable ratio (denominator nonzero and numerator below denominator), each clock adds the numerator to the accumulator. When the sum reaches or exceeds the denominator, the denominator is subtracted and the count rises by exactly one. In that same cycle the tick is high; otherwise the tick is low and the count holds.
- R3: The numerator word is at byte address 0x10 and the denominator word at byte address 0x14. Bits 11:0 of each word are the ratio term. Bits 31:12 are stored as written and read back unchanged, and they have no effect on the count.
- R4: A denominator of zero, or a numerator equal to or greater than the denominator, freezes the count, keeps the tick low and holds the accumulator at zero.
- R5: A write to either ratio word clears the accumulator in that cycle and produces no tick in that cycle. The new ratio then applies from the next clock, starting at zero phase.
- R6: A write to any address other than 0x10 or 0x14 changes no register and does not disturb the accumulator. A read of any such address returns zero.
- R7: Following a ratio write, exactly the numerator's count of ticks occurs in the next denominator-many clocks, for any usable 12-bit pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock whose frequency may vary |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 32 | Write data word |
| rd_addr | input | 8 | Byte address of the combinational read |
| rd_data | output | 32 | Read data word, zero for unmapped addresses |
| count | output | 64 | Free-running realtime count |
| tick | output | 1 | One-cycle pulse in each cycle the count increments |

## Verification
The bench walks through every listed ratio pair and the odd 75/244 pair, then the extreme 4094/4095 pair. Across each denominator-long window it counts ticks; an off-by-one compare (greater-than instead of greater-or-equal) would show up as one tick too few per window. It also writes ratios whose upper bits are all set. A design that used the whole word would see a huge or invalid ratio and stall or miscount. It programs numerator equal to denominator and a zero denominator; a design missing the freeze would wrap every cycle or divide by zero. It writes the same ratio again in mid-run and issues stray writes to neighbouring and misaligned addresses. A design that kept stale phase, or decoded addresses loosely, would drift from the per-clock reference model.

// File: rtl/frc_pkg.sv
// Package: shared sizes and register addresses for the fractional counter.
// Assumes byte addressing with exact word addresses for the two ratio words.
package frc_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int FIELD_W  = 12;
    localparam int CNT_W    = 64;
    localparam logic [ADDR_W-1:0] NUM_ADDR = 8'h10;
    localparam logic [ADDR_W-1:0] DEN_ADDR = 8'h14;
    localparam int NREG     = 2;
    localparam int IDX_NUM  = 0;
    localparam int IDX_DEN  = 1;
endpackage

// File: rtl/frc_regfile.sv
// Ratio register storage. Holds two full-width words; only the low FIELD_W
// bits feed the arithmetic, the rest are kept for software read-modify-write.
// Assumes exact address match; any other address is ignored on write, reads 0.
module frc_regfile
    import frc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int FW = FIELD_W,
    parameter logic [AW-1:0] A_NUM = NUM_ADDR,
    parameter logic [AW-1:0] A_DEN = DEN_ADDR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [FW-1:0] num,
    output logic [FW-1:0] den,
    output logic          ratio_wr
);
    localparam logic [AW-1:0] OFFS [NREG] = '{A_NUM, A_DEN};

    logic [DW-1:0]   words [NREG];
    logic [NREG-1:0] hit;

    // one write-decode per register word
    for (genvar g = 0; g < NREG; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_addr == OFFS[g]);
    end

    // store full words on a matching write, clear on reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (!rst_n)
                words[i] <= '0;
            else if (hit[i])
                words[i] <= wr_data;
        end
    end

    // combinational read mux, zero when no word matches
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == OFFS[i])
                rd_data = words[i];
    end

    assign num      = words[IDX_NUM][FW-1:0];
    assign den      = words[IDX_DEN][FW-1:0];
    assign ratio_wr = |hit;
endmodule

// File: rtl/frc_phase_acc.sv
// Phase accumulator: adds num each clock, wraps at den and flags a step.
// Assumes num < den for a usable ratio; otherwise the phase is held at zero.
module frc_phase_acc #(
    parameter int FW = frc_pkg::FIELD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] num,
    input  logic [FW-1:0] den,
    input  logic          clear,
    output logic          step
);
    logic [FW-1:0] phase;
    logic [FW:0]   sum;
    logic [FW:0]   den_x;
    logic          usable;
    logic          wrap;
    logic [FW-1:0] phase_nxt;

    // next-phase computation and wrap detect
    always_comb begin
        usable = (den != '0) && (num < den);
        den_x  = {1'b0, den};
        sum    = {1'b0, phase} + {1'b0, num};
        wrap   = usable && !clear && (sum >= den_x);
        if (clear || !usable)
            phase_nxt = '0;
        else if (wrap)
            phase_nxt = FW'(sum - den_x);
        else
            phase_nxt = sum[FW-1:0];
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else
            phase <= phase_nxt;
    end

    assign step = wrap;
endmodule

// File: rtl/frc_count.sv
// Wide count register plus a registered tick marking each increment.
// Assumes step is a one-cycle request; the count wraps modulo 2**CW.
module frc_count #(
    parameter int CW = frc_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          tick
);
    // count and tick update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= step;
            if (step)
                count <= count + CW'(1);
        end
    end
endmodule

// File: rtl/frac_rate_counter.sv
// Top: fractional-increment realtime counter. Joins ratio registers, phase
// accumulator and count. Assumes a single clock and synchronous reset.
module frac_rate_counter
    import frc_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int FW = FIELD_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          tick
);
    logic [FW-1:0] num_f;
    logic [FW-1:0] den_f;
    logic          ratio_wr;
    logic          step;

    frc_regfile #(.AW(AW), .DW(DW), .FW(FW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .num(num_f), .den(den_f), .ratio_wr(ratio_wr)
    );

    frc_phase_acc #(.FW(FW)) acc_i (
        .clk(clk), .rst_n(rst_n), .num(num_f), .den(den_f),
        .clear(ratio_wr), .step(step)
    );

    frc_count #(.CW(CW)) cnt_i (
        .clk(clk), .rst_n(rst_n), .step(step), .count(count), .tick(tick)
    );
endmodule

// File: rtl/frc_checker.sv
// Checker: temporal properties of the fractional counter, bound to the top.
// Assumes reset is asserted at time zero for at least two clocks.
module frc_checker #(
    parameter int AW = 8,
    parameter int FW = 12,
    parameter int CW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [FW-1:0] num_f,
    input logic [FW-1:0] den_f,
    input logic [CW-1:0] count,
    input logic          tick
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0) && !tick); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (count == $past(count)) || (count == $past(count) + CW'(1))); // R2

    AST_TICK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tick == (count != $past(count)))); // R2

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && ($past(den_f) == '0 || $past(num_f) >= $past(den_f))
        |-> !tick && $stable(count)); // R4

    AST_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en && (wr_addr == frc_pkg::NUM_ADDR || wr_addr == frc_pkg::DEN_ADDR))
        |-> !tick); // R5
endmodule

bind frac_rate_counter frc_checker #(.AW(AW), .FW(FW), .CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .num_f(num_f), .den_f(den_f), .count(count), .tick(tick)
);

// File: tb/frac_rate_counter_tb_top.sv
`timescale 1ns/1ps
module frac_rate_counter_tb_top;
    localparam logic [7:0] A_NUM = 8'h10;
    localparam logic [7:0] A_DEN = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [63:0] count;
    logic        tick;

    int tests = 0;
    int fails = 0;
    bit chk_on = 0;
    bit done = 0;

    // behavioural reference state
    int unsigned     m_reg [2];
    longint unsigned m_cnt;
    int unsigned     m_acc;
    bit              m_tick;
    int unsigned     mn, md;

    always #2 clk = ~clk;

    frac_rate_counter dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count(count), .tick(tick)
    );

    // reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg[0] = 0; m_reg[1] = 0; m_cnt = 0; m_acc = 0; m_tick = 0;
        end else begin
            mn = m_reg[0] & 32'hFFF;
            md = m_reg[1] & 32'hFFF;
            if (wr_en && (wr_addr == A_NUM || wr_addr == A_DEN)) begin
                m_acc = 0; m_tick = 0;
            end else if (md != 0 && mn < md) begin
                m_acc = m_acc + mn;
                if (m_acc >= md) begin
                    m_acc = m_acc - md; m_cnt = m_cnt + 1; m_tick = 1;
                end else m_tick = 0;
            end else begin
                m_acc = 0; m_tick = 0;
            end
            if (wr_en && wr_addr == A_NUM) m_reg[0] = wr_data;
            if (wr_en && wr_addr == A_DEN) m_reg[1] = wr_data;
        end
    end

    // per-clock comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (chk_on && !done) begin
            tests++;
            if (count !== m_cnt || tick !== m_tick) begin
                fails++;
                $display("FAIL R2 per-clock: count=%0d tick=%0b expected count=%0d tick=%0b",
                         count, tick, m_cnt, m_tick);
            end
        end
    end

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    // program a ratio and count ticks over one denominator window (R7, R5)
    task automatic window(int unsigned n, int unsigned d, string tag);
        longint unsigned c0;
        wr(A_NUM, n);
        wr(A_DEN, d);
        chk({tag, " R5 no tick on write cycle"}, tick, 0);
        c0 = count;
        repeat (d) @(negedge clk);
        chk({tag, " R7 ticks per window"}, count - c0, n);
    endtask

    initial begin
        logic [31:0] rv;
        longint unsigned c0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk_on = 1;
        chk("R1 reset count", count, 0);
        chk("R1 reset tick", tick, 0);
        rd(A_NUM, rv); chk("R1 num reads zero", rv, 0);
        rd(A_DEN, rv); chk("R1 den reads zero", rv, 0);
        rst_n = 1'b1;
        c0 = count;
        repeat (20) @(negedge clk);
        chk("R4 zero den frozen", count, c0);

        window(8, 25, "R2 8/25");
        window(4, 25, "R2 4/25");
        window(64, 125, "R2 64/125");
        window(192, 625, "R2 192/625");
        window(768, 1625, "R2 768/1625");
        window(75, 244, "R2 75/244");
        window(4094, 4095, "R2 4094/4095");
        window(1, 4095, "R2 1/4095");

        // upper bits kept but ignored
        wr(A_NUM, 32'hFFFFF008);
        wr(A_DEN, 32'hABCDE019);
        c0 = count;
        repeat (25) @(negedge clk);
        chk("R3 upper bits ignored", count - c0, 8);
        rd(A_NUM, rv); chk("R3 num readback", rv, 32'hFFFFF008);
        rd(A_DEN, rv); chk("R3 den readback", rv, 32'hABCDE019);

        // stray writes leave registers and phase alone
        wr(A_NUM, 8); wr(A_DEN, 25);
        c0 = count;
        wr(8'h18, 32'h00000001);
        wr(8'h11, 32'h00000003);
        repeat (23) @(negedge clk);
        chk("R6 stray writes no disturb", count - c0, 8);
        rd(8'h18, rv); chk("R6 unmapped reads zero", rv, 0);
        rd(A_NUM, rv); chk("R6 num unchanged", rv, 8);

        // mid-run rewrite clears phase
        repeat (7) @(negedge clk);
        window(8, 25, "R5 rewrite");

        // numerator equal to denominator freezes
        wr(A_NUM, 25);
        c0 = count;
        repeat (60) @(negedge clk);
        chk("R4 num==den frozen", count, c0);
        wr(A_NUM, 30);
        c0 = count;
        repeat (30) @(negedge clk);
        chk("R4 num>den frozen", count, c0);
        chk("R4 tick low", tick, 0);

        // reset mid-run
        wr(A_NUM, 4); wr(A_DEN, 25);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 mid-run reset count", count, 0);
        rd(A_DEN, rv); chk("R1 mid-run reset den", rv, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule